// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block maintenance request may proceed. A request carries one of four operations: zero, clean, flush or invalidate. It also carries an operand address, the current privilege level and a virtualization flag. Three 3-bit enable vectors come with it, one each for the machine, hypervisor and supervisor configuration levels. Two access-permission responses come from the address-checking logic: one says whether the block is readable, the other whether it is writable. One cycle after a request is accepted, the block reports its result. The result is either a clean pass or an exception flag with its cause code, and in both cases it carries the operand address aligned down to the block boundary.

A zero operation that passes all checks drives a simple byte-write port. It issues one zero byte per cycle, covering every byte of the block in ascending order. It does this whatever kind of memory lies behind the port. While the sequence runs, `busy` is held high and new requests are not taken. A one-cycle `done` pulse marks the end of the sequence. A request that fails any check issues no write at all.

Top module: `cbo_perm_unit`

## Requirements
- R1: When the privilege is below machine (encoding U=0, S=1, M=3) and the machine-level enable bit for the operation's class is clear, the result is an exception with code 2 (illegal instruction). This check has precedence over every other check.
- R2: When R1 does not fire and `req_virt` is 1, the result is an exception with code 22 (virtual instruction) in two cases: the privilege is S or U and the hypervisor-level enable bit is clear, or the privilege is U and the supervisor-level enable bit is clear.
- R3: When neither R1 nor R2 fires, a U-mode request whose supervisor-level enable bit is clear gets code 2. The hypervisor-level bit has no effect when `req_virt` is 0.
- R4: Operation encoding: 0 is zero, 1 is clean, 2 is flush, 3 is invalidate. Each enable vector selects by class: bit 0 for zero, bit 1 for clean and flush together, bit 2 for invalidate.
- R5: At machine privilege all three enable vectors are ignored.
- R6: Once the enable checks pass, clean, flush and invalidate pass if the block is readable or writable. If it is neither, the result is code 7 (store access fault).
- R7: Once the enable checks pass, a zero operation needs only `probe_wr_ok`, and readability is ignored. If the block is not writable, the result is code 7.
- R8: `res_valid` pulses in the cycle after a request is accepted. In that cycle `blk_addr` holds the request address with its low log2(BLK_BYTES) bits cleared.
- R9: A zero operation that passes its checks drives `wr_en` for exactly BLK_BYTES consecutive cycles, starting in the same cycle as `res_valid`. Each write carries `wr_data` = 0x00, and `wr_addr` starts at the aligned base and rises by one each cycle.
- R10: `busy` is high exactly while the zero writes are issued. `done` pulses for one cycle right after the last write. Requests presented while `busy` is high are ignored and produce no result.
- R11: A request that fails any check issues no write, and `busy` stays low.
- R12: While reset is held, and right after it is released, `res_valid`, `exc_valid`, `wr_en`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_op | input | 2 | Operation: 0 zero, 1 clean, 2 flush, 3 invalidate |
| req_addr | input | ADDR_W | Operand address |
| req_priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| req_virt | input | 1 | Virtualization active |
| en_mach | input | 3 | Machine-level class enables |
| en_hyp | input | 3 | Hypervisor-level class enables |
| en_sup | input | 3 | Supervisor-level class enables |
| probe_rd_ok | input | 1 | Block readable |
| probe_wr_ok | input | 1 | Block writable |
| res_valid | output | 1 | Result pulse |
| exc_valid | output | 1 | Exception raised (with res_valid) |
| exc_code | output | 5 | Exception cause code |
| blk_addr | output | ADDR_W | Block-aligned address |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write data (zero) |
| busy | output | 1 | Zero sequence running |
| done | output | 1 | Zero sequence finished |

## Verification
Requests are driven on the falling edge, so each one is taken at the following rising edge. The verdict, the cause code and the aligned address are all due at the next falling edge, one cycle after acceptance, and the bench samples them there. For a passing zero operation, the first byte write is due in that same cycle. The bench then checks one write per falling edge for BLK_BYTES edges, and expects the `done` pulse at the edge after that. The bench presents an extra request midway through the sequence and confirms that no result pulse appears before the sequence ends.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } cbo_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int unsigned CODE_W = 5;
  localparam logic [CODE_W-1:0] EXC_ILLEGAL = 5'd2;
  localparam logic [CODE_W-1:0] EXC_STORE   = 5'd7;
  localparam logic [CODE_W-1:0] EXC_VIRT    = 5'd22;

  localparam int unsigned NUM_CLS = 3;

  function automatic logic [1:0] op_class(input logic [1:0] op);
    case (op)
      2'd0:    op_class = 2'd0;
      2'd3:    op_class = 2'd2;
      default: op_class = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/cbo_rst_sync.sv
module cbo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cbo_perm_eval.sv
module cbo_perm_eval
  import cbo_pkg::*;
(
  input  logic [1:0]         op,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [NUM_CLS-1:0] en_m,
  input  logic [NUM_CLS-1:0] en_h,
  input  logic [NUM_CLS-1:0] en_s,
  input  logic               rd_ok,
  input  logic               wr_ok,
  output logic               fault,
  output logic [CODE_W-1:0]  code
);
  logic [1:0] cls;
  logic       m_on, h_on, s_on;
  logic       below_m, at_or_below_s, is_user;
  logic       f_mach, f_virt, f_sup, acc_ok;

  always_comb begin
    cls           = op_class(op);
    m_on          = en_m[cls];
    h_on          = en_h[cls];
    s_on          = en_s[cls];
    below_m       = (priv != PRIV_M);
    at_or_below_s = (priv == PRIV_U) || (priv == PRIV_S);
    is_user       = (priv == PRIV_U);

    f_mach = below_m & ~m_on;
    f_virt = virt & ((at_or_below_s & ~h_on) | (is_user & ~s_on));
    f_sup  = is_user & ~s_on;
    acc_ok = (op == OP_ZERO) ? wr_ok : (rd_ok | wr_ok);

    fault = 1'b1;
    code  = '0;
    if (f_mach)       code = EXC_ILLEGAL;
    else if (f_virt)  code = EXC_VIRT;
    else if (f_sup)   code = EXC_ILLEGAL;
    else if (!acc_ok) code = EXC_STORE;
    else              fault = 1'b0;
  end
endmodule

// File: rtl/cbo_zero_seq.sv
module cbo_zero_seq #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              done
);
  localparam int unsigned OFF_W = $clog2(BLK_BYTES);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BLK_BYTES - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      base_d = base;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      if (start) base_q <= base_d;
    end
  end

  assign wr_en   = busy_q;
  assign wr_addr = base_q + ADDR_W'(cnt_q);
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/cbo_perm_unit.sv
module cbo_perm_unit
  import cbo_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic [2:0]        en_mach,
  input  logic [2:0]        en_hyp,
  input  logic [2:0]        en_sup,
  input  logic              probe_rd_ok,
  input  logic              probe_wr_ok,
  output logic              res_valid,
  output logic              exc_valid,
  output logic [4:0]        exc_code,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

  logic              rst_n_s;
  logic              accept;
  logic              fault;
  logic [CODE_W-1:0] code;
  logic [ADDR_W-1:0] aligned;
  logic              seq_start;

  logic              res_q, res_d;
  logic              exc_q, exc_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [ADDR_W-1:0] addr_q;

  cbo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cbo_perm_eval u_eval (
    .op    (req_op),
    .priv  (req_priv),
    .virt  (req_virt),
    .en_m  (en_mach),
    .en_h  (en_hyp),
    .en_s  (en_sup),
    .rd_ok (probe_rd_ok),
    .wr_ok (probe_wr_ok),
    .fault (fault),
    .code  (code)
  );

  assign accept    = req_valid & ~busy;
  assign aligned   = req_addr & ~OFF_MASK;
  assign seq_start = accept & ~fault & (req_op == OP_ZERO);

  cbo_zero_seq #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (seq_start),
    .base    (aligned),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .busy    (busy),
    .done    (done)
  );

  always_comb begin
    res_d  = accept;
    exc_d  = accept & fault;
    code_d = (accept & fault) ? code : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_q  <= 1'b0;
      exc_q  <= 1'b0;
      code_q <= '0;
      addr_q <= '0;
    end else begin
      res_q  <= res_d;
      exc_q  <= exc_d;
      code_q <= code_d;
      if (accept) addr_q <= aligned;
    end
  end

  assign res_valid = res_q;
  assign exc_valid = exc_q;
  assign exc_code  = code_q;
  assign blk_addr  = addr_q;
  assign wr_data   = 8'h00;
endmodule

// File: rtl/cbo_perm_unit_chk.sv
module cbo_perm_unit_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [1:0]        req_priv,
  input logic [2:0]        en_mach,
  input logic              probe_rd_ok,
  input logic              res_valid,
  input logic              exc_valid,
  input logic [4:0]        exc_code,
  input logic [ADDR_W-1:0] blk_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              done
);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'(BLK_BYTES - 1);
  logic [1:0] cls;
  assign cls = (req_op == 2'd0) ? 2'd0 : ((req_op == 2'd3) ? 2'd2 : 2'd1);

  AST_MACH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_priv != 2'd3 && !en_mach[cls]) |=> (exc_valid && exc_code == 5'd2)); // R1
  AST_MACH_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_priv == 2'd3 && req_op != 2'd0 && probe_rd_ok) |=> !exc_valid); // R5
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((blk_addr & LOW) == '0)); // R8
  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == 8'h00 && busy)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R9
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_valid || $rose(busy)); // R10
  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && exc_valid) |-> !wr_en); // R11
endmodule

bind cbo_perm_unit cbo_perm_unit_chk #(
  .ADDR_W    (ADDR_W),
  .BLK_BYTES (BLK_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_priv    (req_priv),
  .en_mach     (en_mach),
  .probe_rd_ok (probe_rd_ok),
  .res_valid   (res_valid),
  .exc_valid   (exc_valid),
  .exc_code    (exc_code),
  .blk_addr    (blk_addr),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .busy        (busy),
  .done        (done)
);

// File: tb/cbo_perm_unit_tb_top.sv
`timescale 1ns/1ps
module cbo_perm_unit_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned BLK    = 16;
  localparam int unsigned NVEC   = 18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_priv;
  logic              req_virt;
  logic [2:0]        en_mach, en_hyp, en_sup;
  logic              probe_rd_ok, probe_wr_ok;
  logic              res_valid, exc_valid, wr_en, busy, done;
  logic [4:0]        exc_code;
  logic [ADDR_W-1:0] blk_addr, wr_addr;
  logic [7:0]        wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cbo_perm_unit #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_priv(req_priv), .req_virt(req_virt),
    .en_mach(en_mach), .en_hyp(en_hyp), .en_sup(en_sup),
    .probe_rd_ok(probe_rd_ok), .probe_wr_ok(probe_wr_ok),
    .res_valid(res_valid), .exc_valid(exc_valid), .exc_code(exc_code),
    .blk_addr(blk_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  // {op, priv, virt, en_m, en_h, en_s, rd, wr, exp_exc, exp_code}
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b0, 1'b0, 5'd0 },  // R6 readable
    {2'd1, 2'd1, 1'b0, 3'b101, 3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 5'd2 },  // R1 R4 clean
    {2'd2, 2'd1, 1'b0, 3'b101, 3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 5'd2 },  // R4 flush shares bit
    {2'd3, 2'd1, 1'b0, 3'b011, 3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 5'd2 },  // R4 inval bit
    {2'd3, 2'd1, 1'b0, 3'b101, 3'b111, 3'b111, 1'b1, 1'b1, 1'b0, 5'd0 },  // R4 inval ok
    {2'd1, 2'd3, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1, 1'b0, 1'b0, 5'd0 },  // R5
    {2'd1, 2'd1, 1'b1, 3'b111, 3'b101, 3'b111, 1'b1, 1'b1, 1'b1, 5'd22},  // R2 hyp
    {2'd1, 2'd0, 1'b1, 3'b111, 3'b111, 3'b101, 1'b1, 1'b1, 1'b1, 5'd22},  // R2 sup in virt U
    {2'd1, 2'd1, 1'b1, 3'b111, 3'b111, 3'b000, 1'b1, 1'b1, 1'b0, 5'd0 },  // R2 S ignores sup
    {2'd1, 2'd0, 1'b0, 3'b111, 3'b000, 3'b101, 1'b1, 1'b1, 1'b1, 5'd2 },  // R3
    {2'd1, 2'd1, 1'b1, 3'b101, 3'b000, 3'b111, 1'b1, 1'b1, 1'b1, 5'd2 },  // R1 before R2
    {2'd1, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b1, 1'b0, 5'd0 },  // R6 writable
    {2'd1, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 1'b1, 5'd7 },  // R6 fault
    {2'd3, 2'd0, 1'b1, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 1'b1, 5'd7 },  // R6 inval fault
    {2'd0, 2'd1, 1'b0, 3'b110, 3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 5'd2 },  // R4 zero bit
    {2'd0, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b0, 1'b1, 5'd7 },  // R7
    {2'd1, 2'd1, 1'b0, 3'b101, 3'b111, 3'b111, 1'b0, 1'b0, 1'b1, 5'd2 },  // R1 before R6
    {2'd0, 2'd3, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1, 1'b0, 1'b1, 5'd7 }   // R7 at M
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      finish_run();
    end
  end

  task automatic drive(input logic [21:0] v, input logic [31:0] a);
    req_op      = v[21:20];
    req_priv    = v[19:18];
    req_virt    = v[17];
    en_mach     = v[16:14];
    en_hyp      = v[13:11];
    en_sup      = v[10:8];
    probe_rd_ok = v[7];
    probe_wr_ok = v[6];
    req_addr    = a;
    req_valid   = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_priv = '0; req_virt = 1'b0;
    en_mach = '0; en_hyp = '0; en_sup = '0; probe_rd_ok = 1'b0; probe_wr_ok = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset held
    check({res_valid, exc_valid, wr_en, busy, done} == 5'b0, "R12 in reset",
          {27'd0, res_valid, exc_valid, wr_en, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({res_valid, exc_valid, wr_en, busy, done} == 5'b0, "R12 after release",
          {27'd0, res_valid, exc_valid, wr_en, busy, done}, 0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] a;
      logic [31:0] exp_a;
      a = 32'h1000_0000 + i * 32'h0123_4567;
      exp_a = a & ~32'(BLK - 1);
      drive(VEC[i], a);
      @(negedge clk);
      req_valid = 1'b0;
      check(res_valid == 1'b1, $sformatf("R8 res_valid vec%0d", i), {31'd0, res_valid}, 1);
      check(exc_valid == VEC[i][5], $sformatf("R1/R2/R3/R4/R5/R6/R7 exc vec%0d", i),
            {31'd0, exc_valid}, {31'd0, VEC[i][5]});
      check(exc_code == VEC[i][4:0], $sformatf("R1/R2/R3/R6/R7 code vec%0d", i),
            {27'd0, exc_code}, {27'd0, VEC[i][4:0]});
      check(blk_addr == exp_a, $sformatf("R8 aligned vec%0d", i), blk_addr, exp_a);
      if (VEC[i][5]) // R11
        check(!wr_en && !busy, $sformatf("R11 no write vec%0d", i), {30'd0, wr_en, busy}, 0);
      @(negedge clk);
      check(!res_valid && !wr_en, $sformatf("R8 single pulse vec%0d", i), {30'd0, res_valid, wr_en}, 0);
    end

    // Directed: zero sequence, R9 R10
    drive({2'd0, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b1, 6'd0}, 32'h0000_1237);
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid && !exc_valid, "R7 zero pass", {30'd0, res_valid, exc_valid}, 2);
    check(blk_addr == 32'h1230, "R8 zero aligned", blk_addr, 32'h1230);
    for (int j = 0; j < BLK; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 3) begin
        // request while busy must be ignored (R10)
        drive({2'd1, 2'd1, 1'b0, 3'b000, 3'b111, 3'b111, 1'b1, 1'b1, 6'd0}, 32'h0000_9999);
      end
      if (j == 5) req_valid = 1'b0;
      check(wr_en && busy, $sformatf("R9 R10 write strobe %0d", j), {30'd0, wr_en, busy}, 3);
      check(wr_addr == 32'h1230 + j, $sformatf("R9 write addr %0d", j), wr_addr, 32'h1230 + j);
      check(wr_data == 8'h00, $sformatf("R9 write data %0d", j), {24'd0, wr_data}, 0);
      check(!done, $sformatf("R10 no early done %0d", j), {31'd0, done}, 0);
      if (j > 0) check(!res_valid, $sformatf("R10 ignored req %0d", j), {31'd0, res_valid}, 0);
    end
    @(negedge clk);
    check(done && !busy && !wr_en, "R10 done pulse", {29'd0, done, busy, wr_en}, 4);
    check(!res_valid, "R10 ignored req no result", {31'd0, res_valid}, 0);
    @(negedge clk);
    check(!done, "R10 done one cycle", {31'd0, done}, 0);

    // Reset mid-sequence: R12
    drive({2'd0, 2'd3, 1'b0, 3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 6'd0}, 32'h0000_4000);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R9 zero at M starts", {31'd0, busy}, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check({res_valid, exc_valid, wr_en, busy, done} == 5'b0, "R12 async reset",
          {27'd0, res_valid, exc_valid, wr_en, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule